// File: doc/BRIEF.md
# Startup Reset Sequencer with Companion Clock Divider

This block sits next to the crystal input of a metering core. It makes the clock that drives the external converter chips. It also decides when the internal digital logic may leave reset. The output clock is the crystal clock divided by four or by two, picked by one configuration bit. It is a 50% duty square wave that never stops while the crystal runs.

Resets come from two sources. A power-on reset holds every internal block in reset, including the mode signals. Once the power-on reset goes away, the mode signals are released at once, but the core reset stays high for a fixed startup time. That time is counted in crystal cycles. The terminal count is chosen by the two-bit crystal frequency code. A reset command from the serial interface is a one-cycle pulse. It pulses the core reset for one cycle, with no startup delay, and leaves the mode signals alone. The serial interface itself is never reset by this block. A halt flag follows the core reset, so register reads can be marked invalid while any reset is active.

Top module: `startup_reset_ctrl`

## Requirements
- R1: With `half_div` = 0, `clk_out` changes level every 2 crystal cycles, giving a period of 4 cycles at 50% duty.
- R2: With `half_div` = 1, `clk_out` changes level on every crystal cycle, giving a period of 2 cycles.
- R3: `clk_out` keeps toggling during the startup hold and across a remote reset pulse.
- R4: At most three rising clock edges after `por_in` goes high, `core_rst`, `mode_rst` and `halt_flag` are all high. They stay high while `por_in` stays high.
- R5: After `por_in` falls, `mode_rst` falls. `core_rst` then stays high for exactly HOLD_n more cycles and falls. n is the value of `freq_sel`: code 0 = 4.194 MHz, 1 = 4.915 MHz, 2 = 8.192 MHz, 3 = 9.830 MHz. Each code has its own parameter (HOLD_F0 to HOLD_F3).
- R6: A one-cycle `remote_rst` pulse makes `core_rst` high for exactly the next cycle and low again the cycle after. No startup delay is added.
- R7: A remote reset pulse leaves `mode_rst` low.
- R8: `halt_flag` equals `core_rst` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| por_in | input | 1 | Power-on reset, active high, asynchronous assert |
| remote_rst | input | 1 | One-cycle reset request from the serial interface |
| freq_sel | input | 2 | Crystal frequency code, picks the hold count |
| half_div | input | 1 | Output divider select: 0 gives /4, 1 gives /2 |
| clk_out | output | 1 | Divided clock for the converter chips |
| core_rst | output | 1 | Reset for all internal blocks except the serial interface |
| mode_rst | output | 1 | Reset for the mode signals, power-on only |
| halt_flag | output | 1 | Marks register data invalid while reset is active |

## Verification
The bench builds the block with hold counts of 5, 7, 9 and 12 cycles instead of the real 125 ms counts. This keeps every frequency code within a short run. It sweeps all four codes against both divider settings. For each pair it measures the hold length to the exact cycle and counts `clk_out` transitions over a fixed window. These small counts also let it fire remote pulses after each startup, and count the divider transitions across each pulse.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int unsigned FREQ_CODES = 4;
  typedef logic [1:0] freq_code_t;
endpackage

// File: rtl/rsq_por_sync.sv
module rsq_por_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic por_async,
  output logic por_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge por_async) begin
    if (por_async) chain <= '1;
    else           chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign por_sync = chain[STAGES-1];
endmodule

// File: rtl/rsq_hold_timer.sv
module rsq_hold_timer #(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] limit,
  output logic             active
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == limit - 1'b1) active <= 1'b0;
      else                     cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rsq_clk_div.sv
module rsq_clk_div #(
  parameter int unsigned LOG_SLOW = 2,
  parameter int unsigned LOG_FAST = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic fast,
  output logic clk_o
);
  logic [LOG_SLOW-1:0] cnt;
  logic [LOG_SLOW-1:0] cnt_nxt;

  assign cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      clk_o <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      clk_o <= fast ? cnt_nxt[LOG_FAST-1] : cnt_nxt[LOG_SLOW-1];
    end
  end
endmodule

// File: rtl/startup_reset_ctrl.sv
module startup_reset_ctrl
  import rsq_pkg::*;
#(
  parameter int unsigned HOLD_F0   = 524288,
  parameter int unsigned HOLD_F1   = 614400,
  parameter int unsigned HOLD_F2   = 1024000,
  parameter int unsigned HOLD_F3   = 1228800,
  parameter int unsigned LOG_SLOW  = 2,
  parameter int unsigned LOG_FAST  = 1,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic       clk,
  input  logic       por_in,
  input  logic       remote_rst,
  input  logic [1:0] freq_sel,
  input  logic       half_div,
  output logic       clk_out,
  output logic       core_rst,
  output logic       mode_rst,
  output logic       halt_flag
);
  localparam int unsigned MAX01   = (HOLD_F0 > HOLD_F1) ? HOLD_F0 : HOLD_F1;
  localparam int unsigned MAX23   = (HOLD_F2 > HOLD_F3) ? HOLD_F2 : HOLD_F3;
  localparam int unsigned HOLD_MX = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CNT_W   = $clog2(HOLD_MX + 1);

  logic             por_sync;
  logic             hold_active;
  logic [CNT_W-1:0] hold_limit;
  freq_code_t       code;

  assign code = freq_sel;

  always_comb begin
    case (code)
      2'd0:    hold_limit = CNT_W'(HOLD_F0);
      2'd1:    hold_limit = CNT_W'(HOLD_F1);
      2'd2:    hold_limit = CNT_W'(HOLD_F2);
      default: hold_limit = CNT_W'(HOLD_F3);
    endcase
  end

  rsq_por_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk       (clk),
    .por_async (por_in),
    .por_sync  (por_sync)
  );

  rsq_hold_timer #(.CNT_W(CNT_W)) u_hold (
    .clk    (clk),
    .rst    (por_sync),
    .limit  (hold_limit),
    .active (hold_active)
  );

  rsq_clk_div #(.LOG_SLOW(LOG_SLOW), .LOG_FAST(LOG_FAST)) u_div (
    .clk   (clk),
    .rst   (por_sync),
    .fast  (half_div),
    .clk_o (clk_out)
  );

  always_ff @(posedge clk) begin
    mode_rst  <= por_sync;
    core_rst  <= por_sync | hold_active | remote_rst;
    halt_flag <= por_sync | hold_active | remote_rst;
  end
endmodule

// File: rtl/startup_reset_ctrl_chk.sv
module startup_reset_ctrl_chk (
  input logic       clk,
  input logic       por_in,
  input logic       remote_rst,
  input logic [1:0] freq_sel,
  input logic       half_div,
  input logic       clk_out,
  input logic       core_rst,
  input logic       mode_rst,
  input logic       halt_flag
);
  AST_HALT_FOLLOWS_CORE: assert property (@(posedge clk) disable iff (por_in)
    halt_flag == core_rst); // R8

  AST_REMOTE_IMMEDIATE: assert property (@(posedge clk) disable iff (por_in)
    remote_rst |=> core_rst); // R6

  AST_REMOTE_KEEPS_MODE: assert property (@(posedge clk) disable iff (por_in)
    (remote_rst && !mode_rst) |=> !mode_rst); // R7

  AST_MODE_WITHIN_CORE: assert property (@(posedge clk) disable iff (por_in)
    mode_rst |-> core_rst); // R5

  AST_FAST_TOGGLE: assert property (@(posedge clk) disable iff (por_in)
    (half_div && $past(half_div) && !mode_rst && !$past(mode_rst))
      |-> (clk_out != $past(clk_out))); // R2
endmodule

bind startup_reset_ctrl startup_reset_ctrl_chk u_chk (.*);

// File: tb/tb_startup_reset_ctrl.sv
module tb_startup_reset_ctrl;
  localparam int unsigned H0 = 5, H1 = 7, H2 = 9, H3 = 12;

  logic clk = 1'b0;
  logic por_in = 1'b1;
  logic remote_rst = 1'b0;
  logic [1:0] freq_sel = 2'd0;
  logic half_div = 1'b0;
  logic clk_out, core_rst, mode_rst, halt_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  startup_reset_ctrl #(.HOLD_F0(H0), .HOLD_F1(H1), .HOLD_F2(H2), .HOLD_F3(H3)) dut (
    .clk(clk), .por_in(por_in), .remote_rst(remote_rst), .freq_sel(freq_sel),
    .half_div(half_div), .clk_out(clk_out), .core_rst(core_rst),
    .mode_rst(mode_rst), .halt_flag(halt_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hold_of(input int s);
    case (s)
      0: return H0;
      1: return H1;
      2: return H2;
      default: return H3;
    endcase
  endfunction

  task automatic run_case(input int s, input bit h);
    int n, tr, guard;
    logic prev;
    @(negedge clk);
    freq_sel = 2'(s); half_div = h; por_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 core_rst in por", int'(core_rst), 1);
    check("R4 mode_rst in por", int'(mode_rst), 1);
    check("R4 halt_flag in por", int'(halt_flag), 1);
    por_in = 1'b0;
    guard = 0;
    while (mode_rst && guard < 20) begin @(negedge clk); guard++; end
    check("R5 mode_rst released", int'(mode_rst), 0);
    n = 0; tr = 0; prev = clk_out;
    while (core_rst && n < 100) begin
      check("R8 halt during hold", int'(halt_flag), 1);
      @(negedge clk);
      n++;
      if (clk_out != prev) tr++;
      prev = clk_out;
    end
    check("R5 hold length", n, hold_of(s));
    check("R8 halt after hold", int'(halt_flag), 0);
    check("R3 clock runs in hold", int'(tr > 0), 1);
    // steady clock: 16 intervals
    tr = 0; prev = clk_out;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (clk_out != prev) tr++;
      prev = clk_out;
    end
    if (h) check("R2 fast transitions", tr, 16);
    else   check("R1 slow transitions", tr, 8);
    // remote reset pulse
    remote_rst = 1'b1;
    prev = clk_out; tr = 0;
    @(negedge clk);
    remote_rst = 1'b0;
    if (clk_out != prev) tr++;
    prev = clk_out;
    check("R6 core_rst after pulse", int'(core_rst), 1);
    check("R8 halt after pulse", int'(halt_flag), 1);
    check("R7 mode_rst unaffected", int'(mode_rst), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (clk_out != prev) tr++;
      prev = clk_out;
      check("R6 core_rst released", int'(core_rst), 0);
      check("R7 mode_rst stays low", int'(mode_rst), 0);
    end
    check("R3 clock runs across remote", tr, h ? 4 : 2);
  endtask

  initial begin
    for (int s = 0; s < 4; s++)
      for (int h = 0; h < 2; h++)
        run_case(s, h[0]);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule